// File: doc/BRIEF.md
# Configurable Byte-Lane Steering Unit

This block sits between a 16-bit processor data path and a 16-bit data memory. It moves bytes into the right lanes for loads and stores of both words and bytes. A single global byte-order bit works together with address bit 0 to decide whether the two byte lanes are exchanged. When the address is odd, the effect is the same as flipping the order bit. As a result, word accesses can be byte-swapped as well as byte accesses.

Byte loads return the selected memory byte in register bits [7:0], with bits [15:8] cleared. Byte stores place register bits [7:0] in the selected memory lane and enable only that lane, so the other memory byte is kept. Accesses not marked as main-memory data, such as instruction fetches, long literals and the user data area, pass through unchanged. The block is purely combinational and reports the swap decision it made on an observation output.

Top module: `byte_lane_steer`

## Requirements
- R1: Word read with order bit 0 (main data): an even address returns memory data unchanged, and an odd address returns it with bytes [15:8] and [7:0] exchanged.
- R2: Word read with order bit 1 (main data): an even address returns the data byte-exchanged, and an odd address returns it unchanged.
- R3: Word write (main data) drives both write enables (memWrEn = 2'b11; bit 0 is lane [7:0], bit 1 is lane [15:8]). The write data is exchanged exactly when order bit XOR address bit 0 is 1.
- R4: Byte read in the swap case (order 0 even, or order 1 odd) returns memory [15:8] in register [7:0] and zero in register [15:8].
- R5: Byte read in the no-swap case (order 1 even, or order 0 odd) returns memory [7:0] in register [7:0] and zero in register [15:8].
- R6: Byte write in the swap case places register [7:0] on memWrData[15:8] and asserts only memWrEn = 2'b10, so memory byte [7:0] is not written.
- R7: Byte write in the no-swap case places register [7:0] on memWrData[7:0] and asserts only memWrEn = 2'b01.
- R8: A read (wrStrobe = 0) asserts no write enable.
- R9: With mainData = 0, read data equals memory data, write data equals register data, a write asserts memWrEn = 2'b11, and swapEff is 0.
- R10: swapEff is 1 exactly when the access exchanges lanes: order XOR A0 for a word, and its complement for a byte (main data only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgOrder | input | 1 | Global byte-order mode bit (0 or 1) |
| accByte | input | 1 | Access size from opcode: 0 word, 1 byte |
| addrLsb | input | 1 | Address bit 0 |
| wrStrobe | input | 1 | 1 write, 0 read |
| mainData | input | 1 | Access is main-memory data |
| regWrData | input | 16 | Data from processor register for stores |
| memRdData | input | 16 | Data read from memory |
| memWrData | output | 16 | Steered data to memory |
| memWrEn | output | 2 | Byte write enables, bit 0 low lane, bit 1 high lane |
| regRdData | output | 16 | Steered, zero-extended data to processor register |
| swapEff | output | 1 | Lane exchange in effect for this access |

## Verification
Two behaviours overlap in the same evaluation: the lane exchange chosen by the order bit and address bit 0, and the byte-size rules that clear the upper register byte and narrow the write enables. The bench drives byte accesses in all four order and address combinations, using data whose two bytes differ and have non-zero upper halves. Each output is then judged against its expected value. A check passes only if the byte comes from the correct lane, the upper half is cleared, and exactly one enable is set.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef struct packed {
    logic       swapLanes;
    logic       byteAcc;
    logic       zeroUpper;
    logic [1:0] laneWen;
  } steerCtl_t;
endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
(
  input  logic      cfgOrder,
  input  logic      accByte,
  input  logic      addrLsb,
  input  logic      wrStrobe,
  input  logic      mainData,
  output steerCtl_t ctl
);
  logic orderFlip;
  logic doSwap;

  assign orderFlip = cfgOrder ^ addrLsb;
  // byte accesses land in the upper memory lane when the flip is clear
  assign doSwap = accByte ? ~orderFlip : orderFlip;

  always_comb begin
    ctl = '0;
    if (mainData) begin
      ctl.swapLanes = doSwap;
      ctl.byteAcc   = accByte;
      ctl.zeroUpper = accByte & ~wrStrobe;
      if (wrStrobe) begin
        if (accByte) ctl.laneWen = doSwap ? 2'b10 : 2'b01;
        else         ctl.laneWen = 2'b11;
      end
    end else if (wrStrobe) begin
      ctl.laneWen = 2'b11;
    end
  end
endmodule

// File: rtl/lane_steer_datapath.sv
module lane_steer_datapath
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W,
  localparam int LANES = 2
) (
  input  steerCtl_t         ctl,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [LANES-1:0]  memWrEn
);
  logic [LANE_W-1:0] memLo, memHi, regLo, regHi;

  assign memLo = memRdData[LANE_W-1:0];
  assign memHi = memRdData[DATA_W-1:LANE_W];
  assign regLo = regWrData[LANE_W-1:0];
  assign regHi = regWrData[DATA_W-1:LANE_W];

  always_comb begin
    regRdData[LANE_W-1:0]      = ctl.swapLanes ? memHi : memLo;
    regRdData[DATA_W-1:LANE_W] = ctl.zeroUpper ? '0
                               : (ctl.swapLanes ? memLo : memHi);
    memWrData[LANE_W-1:0]      = (ctl.swapLanes && !ctl.byteAcc) ? regHi : regLo;
    memWrData[DATA_W-1:LANE_W] = (ctl.swapLanes || ctl.byteAcc) ? regLo : regHi;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneEn
    assign memWrEn[g] = ctl.laneWen[g];
  end
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              cfgOrder,
  input  logic              accByte,
  input  logic              addrLsb,
  input  logic              wrStrobe,
  input  logic              mainData,
  input  logic [2*LANE_W-1:0] regWrData,
  input  logic [2*LANE_W-1:0] memRdData,
  output logic [2*LANE_W-1:0] memWrData,
  output logic [1:0]        memWrEn,
  output logic [2*LANE_W-1:0] regRdData,
  output logic              swapEff
);
  steerCtl_t ctl;

  lane_steer_ctrl u_ctrl (
    .cfgOrder(cfgOrder), .accByte(accByte), .addrLsb(addrLsb),
    .wrStrobe(wrStrobe), .mainData(mainData), .ctl(ctl)
  );

  lane_steer_datapath #(.LANE_W(LANE_W)) u_dp (
    .ctl(ctl), .regWrData(regWrData), .memRdData(memRdData),
    .memWrData(memWrData), .regRdData(regRdData), .memWrEn(memWrEn)
  );

  assign swapEff = ctl.swapLanes;
endmodule

// File: rtl/byte_lane_steer_chk.sv
module byte_lane_steer_chk #(
  parameter int LANE_W = 8
) (
  input logic                cfgOrder,
  input logic                accByte,
  input logic                addrLsb,
  input logic                wrStrobe,
  input logic                mainData,
  input logic [2*LANE_W-1:0] regWrData,
  input logic [2*LANE_W-1:0] memRdData,
  input logic [2*LANE_W-1:0] memWrData,
  input logic [1:0]          memWrEn,
  input logic [2*LANE_W-1:0] regRdData,
  input logic                swapEff
);
  always_comb begin
    if (!wrStrobe)
      assert_rd_no_wen_R8: assert (memWrEn == 2'b00);
    if (mainData && wrStrobe && !accByte)
      assert_word_wr_both_R3: assert (memWrEn == 2'b11);
    if (mainData && !wrStrobe && accByte)
      assert_byte_rd_zext_R4: assert (regRdData[2*LANE_W-1:LANE_W] == '0);
    if (mainData && wrStrobe && accByte)
      assert_byte_wr_onelane_R6: assert ($countones(memWrEn) == 1);
    if (!mainData)
      assert_passthru_R9: assert (regRdData == memRdData && !swapEff);
    if (mainData && !wrStrobe && !accByte && !(cfgOrder ^ addrLsb))
      assert_word_rd_plain_R1: assert (regRdData == memRdData);
  end
endmodule

bind byte_lane_steer byte_lane_steer_chk #(.LANE_W(LANE_W)) u_chk (
  .cfgOrder(cfgOrder), .accByte(accByte), .addrLsb(addrLsb),
  .wrStrobe(wrStrobe), .mainData(mainData), .regWrData(regWrData),
  .memRdData(memRdData), .memWrData(memWrData), .memWrEn(memWrEn),
  .regRdData(regRdData), .swapEff(swapEff)
);

// File: tb/byte_lane_steer_bench.sv
module byte_lane_steer_bench;
  logic clk = 0;
  always #10 clk = ~clk;

  logic cfgOrder, accByte, addrLsb, wrStrobe, mainData;
  logic [15:0] regWrData, memRdData, memWrData, regRdData;
  logic [1:0] memWrEn;
  logic swapEff;

  int total = 0;
  int bad = 0;

  byte_lane_steer u_byte_lane_steer (
    .cfgOrder(cfgOrder), .accByte(accByte), .addrLsb(addrLsb),
    .wrStrobe(wrStrobe), .mainData(mainData), .regWrData(regWrData),
    .memRdData(memRdData), .memWrData(memWrData), .memWrEn(memWrEn),
    .regRdData(regRdData), .swapEff(swapEff)
  );

  localparam logic [15:0] MEMV = 16'h12B4;
  localparam logic [15:0] REGV = 16'hC3E7;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic b, input logic a, input logic w, input logic md);
    @(negedge clk);
    cfgOrder = m; accByte = b; addrLsb = a; wrStrobe = w; mainData = md;
    regWrData = REGV; memRdData = MEMV;
    #2;
  endtask

  task automatic t_reset_idle();
    apply(0, 0, 0, 0, 1);
    check("R8 idle read enables", {14'd0, memWrEn}, 16'd0);
    check("R1 idle read data", regRdData, MEMV);
  endtask

  task automatic t_word_read();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++) begin
        logic sw;
        sw = m[0] ^ a[0];
        apply(m[0], 0, a[0], 0, 1);
        check(m == 0 ? "R1 word read" : "R2 word read", regRdData,
              sw ? {MEMV[7:0], MEMV[15:8]} : MEMV);
        check("R10 word swap flag", {15'd0, swapEff}, {15'd0, sw});
        check("R8 word read enables", {14'd0, memWrEn}, 16'd0);
      end
  endtask

  task automatic t_word_write();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++) begin
        logic sw;
        sw = m[0] ^ a[0];
        apply(m[0], 0, a[0], 1, 1);
        check("R3 word write data", memWrData, sw ? {REGV[7:0], REGV[15:8]} : REGV);
        check("R3 word write enables", {14'd0, memWrEn}, 16'd3);
      end
  endtask

  task automatic t_byte_read();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++) begin
        logic sw;
        sw = ~(m[0] ^ a[0]);
        apply(m[0], 1, a[0], 0, 1);
        if (sw) check("R4 byte read upper", regRdData, {8'h00, MEMV[15:8]});
        else    check("R5 byte read lower", regRdData, {8'h00, MEMV[7:0]});
        check("R10 byte swap flag", {15'd0, swapEff}, {15'd0, sw});
        check("R8 byte read enables", {14'd0, memWrEn}, 16'd0);
      end
  endtask

  task automatic t_byte_write();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++) begin
        logic sw;
        sw = ~(m[0] ^ a[0]);
        apply(m[0], 1, a[0], 1, 1);
        if (sw) begin
          check("R6 byte write hi data", {8'h00, memWrData[15:8]}, {8'h00, REGV[7:0]});
          check("R6 byte write enables", {14'd0, memWrEn}, 16'd2);
        end else begin
          check("R7 byte write lo data", {8'h00, memWrData[7:0]}, {8'h00, REGV[7:0]});
          check("R7 byte write enables", {14'd0, memWrEn}, 16'd1);
        end
      end
  endtask

  task automatic t_passthru();
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++) begin
        apply(m[0], b[0], 1, 0, 0);
        check("R9 pass read data", regRdData, MEMV);
        check("R9 pass swap flag", {15'd0, swapEff}, 16'd0);
        check("R9 pass read enables", {14'd0, memWrEn}, 16'd0);
        apply(m[0], b[0], 0, 1, 0);
        check("R9 pass write data", memWrData, REGV);
        check("R9 pass write enables", {14'd0, memWrEn}, 16'd3);
      end
  endtask

  initial begin
    cfgOrder = 0; accByte = 0; addrLsb = 0; wrStrobe = 0; mainData = 1;
    regWrData = '0; memRdData = '0;
    t_reset_idle();
    t_word_read();
    t_word_write();
    t_byte_read();
    t_byte_write();
    t_passthru();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule